// File: doc/BRIEF.md
# Integer Result Status Flag Unit

This unit sits beside a 64-bit integer execution pipe and turns each completed result into status flags. It derives a full-width carry, a half-width carry, a full-width overflow, a half-width overflow, a sticky summary-overflow bit and a four-bit condition nibble. The inputs are the operands that fed the operation, an optional immediate and the result itself. The arithmetic that produced the result lives elsewhere; this unit only inspects the operand and result values.

Each instruction presents its values with a one-cycle `valid_i` strobe. Per-flag enables and "already written" markers let the issuing logic choose which flag bits this instruction updates. A divider can hand over its own overflow verdict, which then replaces the sign-based test. The condition nibble goes into one of several fields of a packed condition word, picked by an index input.

Top module: `fx_flag_gen`

## Requirements
- R1: After reset every output is zero: `ca_o`, `ca32_o`, `ov_o`, `ov32_o`, `so_o` and all of `cr_o`.
- R2: Outputs change only on the clock edge where `valid_i` is high, and show the new values from that edge on. With `valid_i` low every output holds.
- R3: The operand set is built as follows. The first operand is `opa_i`, bitwise inverted when `invert_a_i` is high. `opb_i` joins the set when `opb_present_i` is high. `imm_i` joins the set when `imm_valid_i` is high. The second operand for pairwise tests is `opb_i` if present, otherwise `imm_i` if valid, otherwise there is none.
- R4: The full carry is 1 exactly when some operand in the set is unsigned-greater than the 64-bit result.
- R5: When `is_add_i` is high, the half carry is result bit 32 XOR first-operand bit 32 XOR second-operand bit 32 (0 if there is no second operand). Otherwise it is 1 when some operand's low 32 bits are unsigned-greater than the result's low 32 bits.
- R6: The full carry is written only when `carry_en_i` is high and `ca_done_i` is low. The half carry is written only when `carry_en_i` is high and `ca32_done_i` is low. A flag that is not written keeps its value.
- R7: With `ovf_en_i` high and a second operand present, the full overflow is 1 when the first and second operands share a sign bit (bit 63) and the result's sign differs. The half overflow applies the same rule to bit 31. Without a second operand and without a divide verdict, both overflow flags keep their values.
- R8: With `ovf_en_i` and `div_ovf_valid_i` high, both overflow flags take `div_ovf_i`, whether or not a second operand is present.
- R9: `so_o` becomes 1 when the full overflow is written as 1, and nothing except reset clears it.
- R10: With `rec_en_i` high, the field selected by `cr_idx_i` is written as {negative, positive, zero, summary} from bit 3 down to bit 0. The first three come from a signed test of the result. The summary bit is the `so_o` value after this instruction. Field k occupies `cr_o[31-4k : 28-4k]`, so field 0 is the most significant nibble.
- R11: Fields not selected by `cr_idx_i`, and every field when `rec_en_i` is low, keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Instruction strobe |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second register operand |
| opb_present_i | input | 1 | Second register operand is used |
| imm_i | input | 64 | Immediate value |
| imm_valid_i | input | 1 | Immediate is used |
| result_i | input | 64 | Result to inspect |
| invert_a_i | input | 1 | Invert first operand before the tests |
| is_add_i | input | 1 | Operation is an add (selects half-carry rule) |
| carry_en_i | input | 1 | Carry flags may be written |
| ovf_en_i | input | 1 | Overflow flags may be written |
| rec_en_i | input | 1 | Write the condition nibble |
| div_ovf_valid_i | input | 1 | A divide overflow verdict is supplied |
| div_ovf_i | input | 1 | Divide overflow verdict |
| ca_done_i | input | 1 | Full carry already written by the instruction |
| ca32_done_i | input | 1 | Half carry already written by the instruction |
| cr_idx_i | input | 3 | Condition field index |
| ca_o | output | 1 | Full carry flag |
| ca32_o | output | 1 | Half carry flag |
| ov_o | output | 1 | Full overflow flag |
| ov32_o | output | 1 | Half overflow flag |
| so_o | output | 1 | Sticky summary overflow |
| cr_o | output | 32 | Packed condition fields |

## Verification
The properties assume that control inputs are known (never X) on every edge where `valid_i` is high. They also assume that `cr_idx_i` always names an existing field. The stimulus drives every control bit to a defined value on each step, including idle steps. It draws the field index only from the implemented range. Operand, immediate and result values are unconstrained 64-bit patterns. Half of the random steps use a result equal to the true sum, so carries and sign changes occur often rather than rarely.

// File: rtl/fx_flag_pkg.sv
package fx_flag_pkg;

   // condition nibble, most significant bit first
   typedef struct packed {
      logic neg;
      logic pos;
      logic zero;
      logic sum;
   } cond_nib_t;

   localparam int unsigned NIB_W = 4;

endpackage

// File: rtl/fx_flag_carry.sv
module fx_flag_carry #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned N_SRC  = 3
) (
   input  logic [N_SRC-1:0][DATA_W-1:0] src_i,
   input  logic [N_SRC-1:0]             src_ok_i,
   input  logic [DATA_W-1:0]            sec_i,
   input  logic                         sec_ok_i,
   input  logic [DATA_W-1:0]            res_i,
   input  logic                         is_add_i,
   output logic                         ca_o,
   output logic                         ca32_o
);
   localparam int unsigned HALF_W = DATA_W / 2;

   logic [N_SRC-1:0] gt_full;
   logic [N_SRC-1:0] gt_half;

   generate
      if (N_SRC < 1) begin : g_bad
         $error("fx_flag_carry needs at least one source");
      end
      for (genvar s = 0; s < N_SRC; s++) begin : g_src
         assign gt_full[s] = src_ok_i[s] && (src_i[s] > res_i);
         assign gt_half[s] = src_ok_i[s] && (src_i[s][HALF_W-1:0] > res_i[HALF_W-1:0]);
      end
   endgenerate

   logic par_bit;
   assign par_bit = res_i[HALF_W] ^ src_i[0][HALF_W] ^ (sec_ok_i & sec_i[HALF_W]);

   assign ca_o   = |gt_full;
   assign ca32_o = is_add_i ? par_bit : (|gt_half);
endmodule

// File: rtl/fx_flag_ovf.sv
module fx_flag_ovf #(
   parameter int unsigned DATA_W = 64
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              b_ok_i,
   input  logic [DATA_W-1:0] res_i,
   input  logic              div_valid_i,
   input  logic              div_ovf_i,
   output logic              ov_o,
   output logic              ov32_o,
   output logic              known_o
);
   localparam int unsigned HALF_W = DATA_W / 2;

   function automatic logic sign_flip(input logic sa, input logic sb, input logic sr);
      return (sa == sb) && (sr != sa);
   endfunction

   logic ov_sign, ov32_sign;
   assign ov_sign   = sign_flip(a_i[DATA_W-1], b_i[DATA_W-1], res_i[DATA_W-1]);
   assign ov32_sign = sign_flip(a_i[HALF_W-1], b_i[HALF_W-1], res_i[HALF_W-1]);

   assign ov_o    = div_valid_i ? div_ovf_i : ov_sign;
   assign ov32_o  = div_valid_i ? div_ovf_i : ov32_sign;
   assign known_o = div_valid_i | b_ok_i;
endmodule

// File: rtl/fx_flag_cond.sv
module fx_flag_cond #(
   parameter int unsigned DATA_W = 64
) (
   input  logic [DATA_W-1:0] res_i,
   input  logic              sum_i,
   output fx_flag_pkg::cond_nib_t nib_o
);
   logic is_zero;
   assign is_zero    = (res_i == '0);
   assign nib_o.neg  = res_i[DATA_W-1];
   assign nib_o.zero = is_zero;
   assign nib_o.pos  = !res_i[DATA_W-1] && !is_zero;
   assign nib_o.sum  = sum_i;
endmodule

// File: rtl/fx_flag_gen.sv
module fx_flag_gen #(
   parameter int unsigned DATA_W    = 64,
   parameter int unsigned CR_FIELDS = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 valid_i,
   input  logic [DATA_W-1:0]                    opa_i,
   input  logic [DATA_W-1:0]                    opb_i,
   input  logic                                 opb_present_i,
   input  logic [DATA_W-1:0]                    imm_i,
   input  logic                                 imm_valid_i,
   input  logic [DATA_W-1:0]                    result_i,
   input  logic                                 invert_a_i,
   input  logic                                 is_add_i,
   input  logic                                 carry_en_i,
   input  logic                                 ovf_en_i,
   input  logic                                 rec_en_i,
   input  logic                                 div_ovf_valid_i,
   input  logic                                 div_ovf_i,
   input  logic                                 ca_done_i,
   input  logic                                 ca32_done_i,
   input  logic [$clog2(CR_FIELDS)-1:0]         cr_idx_i,
   output logic                                 ca_o,
   output logic                                 ca32_o,
   output logic                                 ov_o,
   output logic                                 ov32_o,
   output logic                                 so_o,
   output logic [CR_FIELDS*fx_flag_pkg::NIB_W-1:0] cr_o
);
   import fx_flag_pkg::*;

   localparam int unsigned N_SRC = 3;
   localparam int unsigned CR_W  = CR_FIELDS * NIB_W;

   generate
      if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_w
         $error("DATA_W must be even and at least 8");
      end
      if (CR_FIELDS < 2) begin : g_bad_f
         $error("CR_FIELDS must be at least 2");
      end
   endgenerate

   // operand set
   logic [N_SRC-1:0][DATA_W-1:0] src;
   logic [N_SRC-1:0]             src_ok;
   logic [DATA_W-1:0]            sec;
   logic                         sec_ok;

   assign src[0]    = invert_a_i ? ~opa_i : opa_i;
   assign src_ok[0] = 1'b1;
   assign src[1]    = opb_i;
   assign src_ok[1] = opb_present_i;
   assign src[2]    = imm_i;
   assign src_ok[2] = imm_valid_i;
   assign sec       = opb_present_i ? opb_i : imm_i;
   assign sec_ok    = opb_present_i | imm_valid_i;

   logic ca_n, ca32_n, ov_n, ov32_n, ov_known;

   fx_flag_carry #(.DATA_W(DATA_W), .N_SRC(N_SRC)) u_carry (
      .src_i    (src),
      .src_ok_i (src_ok),
      .sec_i    (sec),
      .sec_ok_i (sec_ok),
      .res_i    (result_i),
      .is_add_i (is_add_i),
      .ca_o     (ca_n),
      .ca32_o   (ca32_n)
   );

   fx_flag_ovf #(.DATA_W(DATA_W)) u_ovf (
      .a_i         (src[0]),
      .b_i         (sec),
      .b_ok_i      (sec_ok),
      .res_i       (result_i),
      .div_valid_i (div_ovf_valid_i),
      .div_ovf_i   (div_ovf_i),
      .ov_o        (ov_n),
      .ov32_o      (ov32_n),
      .known_o     (ov_known)
   );

   logic wr_ca, wr_ca32, wr_ov, so_q, so_n;
   assign wr_ca   = valid_i && carry_en_i && !ca_done_i;
   assign wr_ca32 = valid_i && carry_en_i && !ca32_done_i;
   assign wr_ov   = valid_i && ovf_en_i && ov_known;
   assign so_n    = so_q | (wr_ov & ov_n);

   cond_nib_t nib;
   fx_flag_cond #(.DATA_W(DATA_W)) u_cond (
      .res_i (result_i),
      .sum_i (so_n),
      .nib_o (nib)
   );

   logic ca_q, ca32_q, ov_q, ov32_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ca_q   <= 1'b0;
         ca32_q <= 1'b0;
         ov_q   <= 1'b0;
         ov32_q <= 1'b0;
         so_q   <= 1'b0;
      end else begin
         if (wr_ca)   ca_q   <= ca_n;
         if (wr_ca32) ca32_q <= ca32_n;
         if (wr_ov) begin
            ov_q   <= ov_n;
            ov32_q <= ov32_n;
         end
         if (valid_i) so_q <= so_n;
      end
   end

   logic [CR_W-1:0] cr_q;
   generate
      for (genvar f = 0; f < CR_FIELDS; f++) begin : g_fld
         localparam int unsigned LSB = (CR_FIELDS - 1 - f) * NIB_W;
         logic hit;
         assign hit = valid_i && rec_en_i && (cr_idx_i == f);
         always_ff @(posedge clk) begin
            if (!rst_n)   cr_q[LSB +: NIB_W] <= '0;
            else if (hit) cr_q[LSB +: NIB_W] <= nib;
         end
      end
   endgenerate

   assign ca_o   = ca_q;
   assign ca32_o = ca32_q;
   assign ov_o   = ov_q;
   assign ov32_o = ov32_q;
   assign so_o   = so_q;
   assign cr_o   = cr_q;
endmodule

// File: rtl/fx_flag_chk.sv
module fx_flag_chk #(
   parameter int unsigned CR_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            valid_i,
   input logic            carry_en_i,
   input logic            ovf_en_i,
   input logic            rec_en_i,
   input logic            div_ovf_valid_i,
   input logic            div_ovf_i,
   input logic            ca_done_i,
   input logic            ca_o,
   input logic            ca32_o,
   input logic            ov_o,
   input logic            ov32_o,
   input logic            so_o,
   input logic [CR_W-1:0] cr_o
);
   assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> $stable({ca_o, ca32_o, ov_o, ov32_o, so_o, cr_o}));

   assert_ca_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && ca_done_i) |=> $stable(ca_o));

   assert_ca_noen_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !carry_en_i) |=> $stable({ca_o, ca32_o}));

   assert_div_verdict_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && ovf_en_i && div_ovf_valid_i) |=>
         (ov_o == $past(div_ovf_i)) && (ov32_o == $past(div_ovf_i)));

   assert_so_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      so_o |=> so_o);

   assert_so_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ov_o) |-> so_o);

   assert_cr_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !rec_en_i) |=> $stable(cr_o));
endmodule

bind fx_flag_gen fx_flag_chk #(.CR_W(CR_W)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .valid_i         (valid_i),
   .carry_en_i      (carry_en_i),
   .ovf_en_i        (ovf_en_i),
   .rec_en_i        (rec_en_i),
   .div_ovf_valid_i (div_ovf_valid_i),
   .div_ovf_i       (div_ovf_i),
   .ca_done_i       (ca_done_i),
   .ca_o            (ca_o),
   .ca32_o          (ca32_o),
   .ov_o            (ov_o),
   .ov32_o          (ov32_o),
   .so_o            (so_o),
   .cr_o            (cr_o)
);

// File: tb/sim_fx_flag_gen.sv
`timescale 1ns/1ps
module sim_fx_flag_gen;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic        valid_i = 0, opb_present_i = 0, imm_valid_i = 0, invert_a_i = 0, is_add_i = 0;
   logic        carry_en_i = 0, ovf_en_i = 0, rec_en_i = 0, div_ovf_valid_i = 0, div_ovf_i = 0;
   logic        ca_done_i = 0, ca32_done_i = 0;
   logic [63:0] opa_i = 0, opb_i = 0, imm_i = 0, result_i = 0;
   logic [2:0]  cr_idx_i = 0;
   logic        ca_o, ca32_o, ov_o, ov32_o, so_o;
   logic [31:0] cr_o;

   fx_flag_gen u0 (.*);

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   // reference state
   bit m_ca, m_ca32, m_ov, m_ov32, m_so;
   logic [31:0] m_cr;

   task automatic chk1(input string tag, input string nm, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s got=%h exp=%h", tag, nm, got, exp);
      end
   endtask

   task automatic compare(input string tag);
      chk1({tag, " R4"}, "ca", 32'(ca_o), 32'(m_ca));
      chk1({tag, " R5"}, "ca32", 32'(ca32_o), 32'(m_ca32));
      chk1({tag, " R7"}, "ov", 32'(ov_o), 32'(m_ov));
      chk1({tag, " R7"}, "ov32", 32'(ov32_o), 32'(m_ov32));
      chk1({tag, " R9"}, "so", 32'(so_o), 32'(m_so));
      chk1({tag, " R10"}, "cr", cr_o, m_cr);
   endtask

   function automatic bit ugt(input logic [63:0] x, input logic [63:0] y);
      return x > y;
   endfunction

   // reference update, applied for a strobe
   task automatic model();
      logic [63:0] a, b;
      bit has_b, c, c32, o, o32, neg, pos, zer;
      longint sr;
      if (!valid_i) return;
      a = invert_a_i ? ~opa_i : opa_i;
      has_b = opb_present_i || imm_valid_i;
      b = opb_present_i ? opb_i : (imm_valid_i ? imm_i : 64'd0);
      c = ugt(a, result_i) || (opb_present_i && ugt(opb_i, result_i)) ||
          (imm_valid_i && ugt(imm_i, result_i));
      if (is_add_i) c32 = result_i[32] ^ a[32] ^ b[32];
      else c32 = (a[31:0] > result_i[31:0]) ||
                 (opb_present_i && opb_i[31:0] > result_i[31:0]) ||
                 (imm_valid_i && imm_i[31:0] > result_i[31:0]);
      if (carry_en_i && !ca_done_i)   m_ca = c;
      if (carry_en_i && !ca32_done_i) m_ca32 = c32;
      if (ovf_en_i && (div_ovf_valid_i || has_b)) begin
         if (div_ovf_valid_i) begin
            o = div_ovf_i; o32 = div_ovf_i;
         end else begin
            o   = ($signed(a) < 0) == ($signed(b) < 0) && (($signed(result_i) < 0) != ($signed(a) < 0));
            o32 = ($signed(a[31:0]) < 0) == ($signed(b[31:0]) < 0) &&
                  (($signed(result_i[31:0]) < 0) != ($signed(a[31:0]) < 0));
         end
         m_ov = o; m_ov32 = o32;
         if (o) m_so = 1;
      end
      if (rec_en_i) begin
         sr = $signed(result_i);
         neg = sr < 0; pos = sr > 0; zer = sr == 0;
         m_cr[(7 - int'(cr_idx_i))*4 +: 4] = {neg, pos, zer, m_so};
      end
   endtask

   task automatic idle_ctl();
      valid_i = 0; opb_present_i = 0; imm_valid_i = 0; invert_a_i = 0; is_add_i = 0;
      carry_en_i = 0; ovf_en_i = 0; rec_en_i = 0; div_ovf_valid_i = 0; div_ovf_i = 0;
      ca_done_i = 0; ca32_done_i = 0; cr_idx_i = 0;
   endtask

   // inputs are set at a falling edge; step applies one rising edge and checks
   task automatic step(input string tag);
      model();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++; n_chk++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : stim
      m_ca = 0; m_ca32 = 0; m_ov = 0; m_ov32 = 0; m_so = 0; m_cr = '0;
      repeat (3) @(negedge clk);
      compare("R1 reset");
      rst_n = 1;
      @(negedge clk);

      // add with wrap: carry and half carry by parity
      idle_ctl(); valid_i = 1; is_add_i = 1; carry_en_i = 1; opb_present_i = 1;
      opa_i = '1; opb_i = 64'd1; result_i = 64'd0;
      step("R4 R5 add wrap");

      // carry already written: full carry kept, half carry updated (R6)
      idle_ctl(); valid_i = 1; carry_en_i = 1; ca_done_i = 1; opb_present_i = 1;
      opa_i = 64'd1; opb_i = 64'd2; result_i = 64'h1_0000_0003;
      step("R6 ca suppressed");

      // inverted first operand (R3): ~0 is greater than result
      idle_ctl(); valid_i = 1; carry_en_i = 1; invert_a_i = 1;
      opa_i = 64'd0; result_i = 64'd5;
      step("R3 invert");

      // immediate as second operand (R3)
      idle_ctl(); valid_i = 1; carry_en_i = 1; imm_valid_i = 1;
      opa_i = 64'd1; imm_i = 64'd100; result_i = 64'd50;
      step("R3 immediate");

      // signed overflow at full width only; summary set (R7 R9)
      idle_ctl(); valid_i = 1; ovf_en_i = 1; opb_present_i = 1;
      opa_i = 64'h7FFF_FFFF_FFFF_FFFF; opb_i = 64'd1; result_i = 64'h8000_0000_0000_0000;
      step("R7 R9 ovf");

      // no overflow afterwards: summary stays (R9)
      idle_ctl(); valid_i = 1; ovf_en_i = 1; opb_present_i = 1;
      opa_i = 64'd1; opb_i = 64'd1; result_i = 64'd2;
      step("R9 sticky");

      // no second operand: overflow flags keep (R7)
      idle_ctl(); valid_i = 1; ovf_en_i = 1;
      opa_i = 64'h7FFF_FFFF_7FFF_FFFF; result_i = 64'h8000_0000_8000_0000;
      step("R7 no second operand");

      // divide verdict without second operand (R8)
      idle_ctl(); valid_i = 1; ovf_en_i = 1; div_ovf_valid_i = 1; div_ovf_i = 1;
      opa_i = 64'd4; result_i = 64'd2;
      step("R8 div verdict 1");
      idle_ctl(); valid_i = 1; ovf_en_i = 1; div_ovf_valid_i = 1; div_ovf_i = 0; opb_present_i = 1;
      opa_i = 64'h7FFF_FFFF_FFFF_FFFF; opb_i = 64'd1; result_i = 64'h8000_0000_0000_0000;
      step("R8 div verdict 0");

      // record to field 5 and field 0 (R10), others untouched (R11)
      idle_ctl(); valid_i = 1; rec_en_i = 1; cr_idx_i = 3'd5; result_i = 64'hF000_0000_0000_0000;
      step("R10 R11 field5 neg");
      idle_ctl(); valid_i = 1; rec_en_i = 1; cr_idx_i = 3'd0; result_i = 64'd0;
      step("R10 R11 field0 zero");
      idle_ctl(); valid_i = 1; rec_en_i = 1; cr_idx_i = 3'd7; result_i = 64'd9;
      step("R10 field7 pos");

      // strobe low with every enable high: nothing changes (R2)
      idle_ctl(); carry_en_i = 1; ovf_en_i = 1; rec_en_i = 1; cr_idx_i = 3'd2;
      opa_i = '1; result_i = 64'd0; div_ovf_valid_i = 1; div_ovf_i = 1;
      step("R2 idle hold");

      // record disabled: condition word unchanged (R11)
      idle_ctl(); valid_i = 1; carry_en_i = 1; cr_idx_i = 3'd1; result_i = 64'd3; opa_i = 64'd4;
      step("R11 no record");

      // reset again so random phase starts with summary clear
      rst_n = 0;
      m_ca = 0; m_ca32 = 0; m_ov = 0; m_ov32 = 0; m_so = 0; m_cr = '0;
      idle_ctl();
      @(posedge clk); @(negedge clk);
      compare("R1 second reset");
      rst_n = 1;

      for (int i = 0; i < 400; i++) begin
         valid_i = ($urandom % 4) != 0;
         opb_present_i = $urandom % 2; imm_valid_i = $urandom % 2;
         invert_a_i = ($urandom % 4) == 0; is_add_i = $urandom % 2;
         carry_en_i = $urandom % 2; ovf_en_i = ($urandom % 3) != 0; rec_en_i = $urandom % 2;
         div_ovf_valid_i = ($urandom % 5) == 0; div_ovf_i = $urandom % 2;
         ca_done_i = ($urandom % 4) == 0; ca32_done_i = ($urandom % 4) == 0;
         cr_idx_i = 3'($urandom % 8);
         opa_i = {$urandom, $urandom}; opb_i = {$urandom, $urandom};
         imm_i = {$urandom, $urandom};
         if ($urandom % 2) result_i = (invert_a_i ? ~opa_i : opa_i) + opb_i;
         else result_i = {$urandom, $urandom};
         step("R2 R3 R6 R8 R11 random");
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule